// File: doc/BRIEF.md
# Delayed-Start Serial Word Receiver

This block takes a serial data line and a frame-synchronization line, both sampled on the rising edge of one bit clock, and turns each frame into a parallel word. A frame begins at the first clock edge at which the synchronization input is seen high while the receiver is idle. A two-bit delay code sets how many bit clocks separate that edge from the edge that captures the first data bit. With a delay of zero, the first bit is captured on the synchronization edge itself. With a delay of one, it is captured one edge later, which suits a sync pulse one bit wide. With a delay of two, the bit between them is treated as a framing bit and dropped, which suits streams where a framing bit comes before the payload.

Bits arrive most significant first. Once the last bit of the word has been captured, the block updates its parallel output, pulses a one-cycle valid strobe, and goes back to waiting for the next synchronization edge. The delay code in effect for a frame is the value the code has when that frame starts. The unused code value is handled as the two-bit delay, and it also sets a flag that stays high until reset.

Top module: `frame_rx`

## Requirements
- R1: A frame starts at the first rising clock edge at which `fsync` is sampled high while the receiver is idle. `fsync` is ignored while a frame is being received.
- R2: With `dly_sel` = 2'b00, the first data bit is the `sdata` value sampled on the same edge that detects the frame start.
- R3: With `dly_sel` = 2'b01, the first data bit is the `sdata` value sampled one edge after the frame-start edge.
- R4: With `dly_sel` = 2'b10, the `sdata` value sampled one edge after the frame-start edge is discarded as a framing bit. The first data bit is sampled two edges after the frame-start edge.
- R5: A word is WORD_W (default 8) consecutive data bits, sent most significant first. The first data bit lands in `word_out[WORD_W-1]` and the last in `word_out[0]`.
- R6: `word_out` is updated on the edge that captures the last data bit, and `word_vld` is high for exactly the one cycle after that edge. At all other times `word_out` holds its value. A new frame start is accepted on the next edge after that.
- R7: `dly_sel` = 2'b11 gives the same timing as 2'b10. Any clock edge outside reset at which `dly_sel` is 2'b11 sets `cfg_err`, and `cfg_err` stays high until reset.
- R8: The delay code is taken at the frame-start edge. Changes to `dly_sel` during a frame have no effect on that frame.
- R9: A synchronous active-high `rst` clears the shift register, the bit counter, `word_out`, `word_vld` and `cfg_err`. It also abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dly_sel | input | 2 | Data-delay code: 00 = 0 bits, 01 = 1 bit, 10 = 2 bits, 11 = unused (handled as 2, flagged) |
| fsync | input | 1 | Frame synchronization, active high |
| sdata | input | 1 | Serial data, most significant bit first |
| word_out | output | WORD_W | Last completed word |
| word_vld | output | 1 | One-cycle strobe marking a new `word_out` |
| cfg_err | output | 1 | Sticky flag for the unused delay code |

## Verification
The bench places random noise on `sdata` in the cycles before the first data bit, so a delay that is off by one edge shows up as a shifted word, or as a word that contains the framing bit. It raises `fsync` at random inside frames and changes `dly_sel` at random during frames. A receiver that restarts on a late sync, or that reads the delay code on every edge, therefore returns the wrong word. It also sends frames back to back, with no idle cycle after the valid strobe, which exposes a receiver that misses a sync arriving one edge after the strobe. Finally, it resets in the middle of a frame and then sends a full frame, which exposes a bit counter that survives reset. It also checks that the unused code keeps the two-bit timing and leaves `cfg_err` high until reset.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_DATA = 2'd2
   } rx_state_e;

endpackage

// File: rtl/frame_rx_cfg.sv
module frame_rx_cfg #(
   parameter int DLY_W   = 2,
   parameter int MAX_DLY = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DLY_W-1:0] dly_sel,
   output logic [DLY_W-1:0] dly_eff,
   output logic             cfg_err
);

   localparam logic [DLY_W-1:0] MAX_CODE = DLY_W'(MAX_DLY);

   logic code_bad;

   // Codes above the largest legal delay fall back to that delay.
   assign code_bad = (dly_sel > MAX_CODE);
   assign dly_eff  = code_bad ? MAX_CODE : dly_sel;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_err <= 1'b0;
      end else if (code_bad) begin
         cfg_err <= 1'b1;
      end
   end

endmodule

// File: rtl/frame_rx_ctrl.sv
module frame_rx_ctrl
   import frame_rx_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DLY_W  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fsync,
   input  logic [DLY_W-1:0] dly_eff,
   output logic             shift_en,
   output logic             last_bit
);

   localparam int              CNT_W    = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
   localparam logic [DLY_W-1:0] ONE_DLY  = DLY_W'(1);

   rx_state_e        state_q, state_d;
   logic [CNT_W-1:0] bcnt_q, bcnt_d;
   logic [DLY_W-1:0] wcnt_q, wcnt_d;

   always_comb begin
      state_d  = state_q;
      bcnt_d   = bcnt_q;
      wcnt_d   = wcnt_q;
      shift_en = 1'b0;
      last_bit = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (fsync) begin
               if (dly_eff == '0) begin
                  shift_en = 1'b1;
                  bcnt_d   = CNT_W'(1);
                  state_d  = ST_DATA;
               end else begin
                  wcnt_d  = dly_eff;
                  state_d = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            if (wcnt_q == ONE_DLY) begin
               shift_en = 1'b1;
               bcnt_d   = CNT_W'(1);
               state_d  = ST_DATA;
            end else begin
               wcnt_d = wcnt_q - ONE_DLY;
            end
         end
         ST_DATA: begin
            shift_en = 1'b1;
            if (bcnt_q == LAST_IDX) begin
               last_bit = 1'b1;
               bcnt_d   = '0;
               state_d  = ST_IDLE;
            end else begin
               bcnt_d = bcnt_q + CNT_W'(1);
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         bcnt_q  <= '0;
         wcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         bcnt_q  <= bcnt_d;
         wcnt_q  <= wcnt_d;
      end
   end

endmodule

// File: rtl/frame_rx_shift.sv
module frame_rx_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              last_bit,
   input  logic              sdata,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld
);

   logic [WORD_W-1:0] sreg_q;
   logic [WORD_W-1:0] sreg_nxt;

   // Newest bit enters at position 0; the oldest ends up at the MSB.
   assign sreg_nxt[0] = sdata;
   generate
      for (genvar i = 1; i < WORD_W; i++) begin : g_stage
         assign sreg_nxt[i] = sreg_q[i-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sreg_q   <= '0;
         word_out <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= last_bit;
         if (shift_en) begin
            sreg_q <= sreg_nxt;
         end
         if (last_bit) begin
            word_out <= sreg_nxt;
         end
      end
   end

endmodule

// File: rtl/frame_rx.sv
module frame_rx #(
   parameter int WORD_W  = 8,
   parameter int DLY_W   = 2,
   parameter int MAX_DLY = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        dly_sel,
   input  logic              fsync,
   input  logic              sdata,
   output logic [WORD_W-1:0] word_out,
   output logic              word_vld,
   output logic              cfg_err
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("frame_rx: WORD_W must be at least 2");
      end
      if (DLY_W != 2) begin : g_bad_dly_w
         $error("frame_rx: DLY_W must match the 2-bit dly_sel port");
      end
      if (MAX_DLY < 0 || MAX_DLY >= (1 << DLY_W)) begin : g_bad_max
         $error("frame_rx: MAX_DLY out of range for DLY_W");
      end
   endgenerate

   logic [DLY_W-1:0] dly_eff;
   logic             shift_en;
   logic             last_bit;

   frame_rx_cfg #(
      .DLY_W   (DLY_W),
      .MAX_DLY (MAX_DLY)
   ) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .dly_sel (dly_sel),
      .dly_eff (dly_eff),
      .cfg_err (cfg_err)
   );

   frame_rx_ctrl #(
      .WORD_W (WORD_W),
      .DLY_W  (DLY_W)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .fsync    (fsync),
      .dly_eff  (dly_eff),
      .shift_en (shift_en),
      .last_bit (last_bit)
   );

   frame_rx_shift #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (shift_en),
      .last_bit (last_bit),
      .sdata    (sdata),
      .word_out (word_out),
      .word_vld (word_vld)
   );

endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
   parameter int WORD_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        dly_sel,
   input logic [WORD_W-1:0] word_out,
   input logic              word_vld,
   input logic              cfg_err
);

   // R6
   vld_single_chk: assert property (@(posedge clk) disable iff (rst)
      word_vld |=> !word_vld);

   // R6
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !word_vld |-> $stable(word_out));

   // R7
   err_set_chk: assert property (@(posedge clk) disable iff (rst)
      (dly_sel == 2'b11) |=> cfg_err);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_err |=> cfg_err);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!word_vld && word_out == '0 && !cfg_err));

endmodule

bind frame_rx frame_rx_chk #(.WORD_W(WORD_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .dly_sel  (dly_sel),
   .word_out (word_out),
   .word_vld (word_vld),
   .cfg_err  (cfg_err)
);

// File: tb/sim_frame_rx.sv
module sim_frame_rx;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] dly_sel = 2'b00;
   logic       fsync = 1'b0;
   logic       sdata = 1'b0;
   logic [7:0] word_out;
   logic       word_vld;
   logic       cfg_err;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;
   int  seed_sink;

   always #2 clk = ~clk;

   frame_rx u0 (
      .clk      (clk),
      .rst      (rst),
      .dly_sel  (dly_sel),
      .fsync    (fsync),
      .sdata    (sdata),
      .word_out (word_out),
      .word_vld (word_vld),
      .cfg_err  (cfg_err)
   );

   function automatic int eff_delay(input logic [1:0] code);
      return (code == 2'b11) ? 2 : int'(code);
   endfunction

   function automatic string delay_req(input logic [1:0] code);
      case (code)
         2'b00:   return "R2 R5";
         2'b01:   return "R3 R5";
         2'b10:   return "R4 R5";
         default: return "R7 R5";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   // One frame; noisy sync and code changes exercise R1 and R8.
   task automatic send_frame(input logic [1:0] code, input logic [7:0] w,
                             input bit noisy_sync, input bit chg_code);
      int d = eff_delay(code);
      for (int k = 0; k < d + 8; k++) begin
         @(negedge clk);
         if (k == 1) check(word_vld == 1'b0, "R6 strobe width", int'(word_vld), 0);
         fsync = (k == 0) ? 1'b1 : (noisy_sync ? 1'($urandom % 2) : 1'b0);
         if (k == 0) dly_sel = code;
         else if (chg_code) dly_sel = 2'($urandom % 3);
         if (k >= d) sdata = w[7 - (k - d)];
         else sdata = 1'($urandom % 2);
      end
      @(negedge clk);
      check(word_vld == 1'b1, {delay_req(code), " R8 valid"}, int'(word_vld), 1);
      check(word_out == w, {delay_req(code), " R1 R8 word"}, int'(word_out), int'(w));
      fsync = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check(word_vld == 1'b0, "R1 idle no strobe", int'(word_vld), 0);
         fsync = 1'b0;
         sdata = 1'($urandom % 2);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      seed_sink = $urandom(32'h5EED_1234);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(word_vld == 1'b0, "R9 vld", int'(word_vld), 0);
      check(word_out == 8'h00, "R9 word", int'(word_out), 0);
      check(cfg_err == 1'b0, "R9 err", int'(cfg_err), 0);
      rst = 1'b0;
      idle_cycles(3);

      // Directed: each legal delay, back to back (R6)
      send_frame(2'b00, 8'hA5, 1'b0, 1'b0);
      send_frame(2'b01, 8'h3C, 1'b0, 1'b0);
      send_frame(2'b10, 8'h81, 1'b0, 1'b0);
      send_frame(2'b00, 8'h01, 1'b0, 1'b0);
      send_frame(2'b10, 8'hFE, 1'b0, 1'b0);
      idle_cycles(2);

      // Random frames with noisy sync, changing code, random gaps
      for (int i = 0; i < 60; i++) begin
         send_frame(2'($urandom % 3), 8'($urandom), 1'b1, 1'b1);
         idle_cycles(int'($urandom % 3));
      end
      idle_cycles(1);
      check(cfg_err == 1'b0, "R7 no false error", int'(cfg_err), 0);

      // R9: reset mid-frame, then a clean frame must decode
      @(negedge clk);
      fsync = 1'b1; dly_sel = 2'b00; sdata = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         fsync = 1'b0; sdata = 1'b1;
      end
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(word_vld == 1'b0 && word_out == 8'h00, "R9 mid-frame reset",
            int'({word_vld, word_out}), 0);
      rst = 1'b0;
      send_frame(2'b01, 8'h5A, 1'b0, 1'b0);
      idle_cycles(1);

      // R7: unused code behaves as two-bit delay and sets the sticky flag
      send_frame(2'b11, 8'hC3, 1'b0, 1'b0);
      check(cfg_err == 1'b1, "R7 error set", int'(cfg_err), 1);
      send_frame(2'b01, 8'h96, 1'b0, 1'b0);
      idle_cycles(2);
      check(cfg_err == 1'b1, "R7 error sticky", int'(cfg_err), 1);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(cfg_err == 1'b0, "R9 error cleared", int'(cfg_err), 0);
      rst = 1'b0;
      idle_cycles(2);

      finish_run();
   end

endmodule